// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 128K words by 16 bits. It accepts one read or one write at a time through a valid/ready handshake. Each request carries a word address, write data, a two-bit lane mask and a direction flag. The block then drives the memory's active-low select, write strobe, output enable and two byte-lane enables through a timed sequence.

All memory timing comes from cycle counts. Each count is a nanosecond figure divided by the clock-period parameter, rounded up, and never less than one. The block gives up the data bus before the memory may drive it, and it inserts idle cycles whenever the direction of traffic changes. Read data is registered and returned with a single-cycle valid pulse. Between transactions the memory is held in standby.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, and whenever no transaction is in progress, the chip select, write strobe, output enable and both lane enables are high, the data-bus drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A write holds chip select and write strobe low together, with output enable high, for exactly N_WR cycles. N_WR is the largest of ceil(55/CLK_NS), ceil(40/CLK_NS), ceil(25/CLK_NS) and ceil(50/CLK_NS). Address and write data stay constant over that window, and both strobes rise on the same edge to end it.
- R3: Lane mask bit 0 set drives the lower enable low, which covers data bits 7:0. Mask bit 1 set drives the upper enable low, which covers data bits 15:8. A lane whose bit is clear keeps its memory contents across a write.
- R4: A read holds chip select and output enable low, with write strobe high, for exactly N_RD = max(ceil(55/CLK_NS), ceil(25/CLK_NS)) cycles. The bus value is captured on the last of these cycles. `rsp_valid` then pulses high for one cycle, with that value on `rsp_rdata`.
- R5: On a read, a lane whose mask bit is clear returns zero in its eight bits of `rsp_rdata`.
- R6: A mask of 00 keeps both lane enables high for the whole access. A write with this mask changes no memory byte, and a read with it returns 0.
- R7: The data-bus drive enable is high only while chip select and write strobe are both low and output enable is high.
- R8: The write strobe and the output enable are never low in the same cycle.
- R9: When a read follows a write, or a write follows a read, at least ceil(25/CLK_NS) cycles pass between the two accesses. In those cycles all memory strobes are high and the bus is not driven.
- R10: `req_ready` is low from the cycle after a request is accepted until the access has finished. A request is taken only on an edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte, 1 = enabled |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_o | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The bench builds the controller with a 10 ns clock period. This makes every timing figure span several cycles: six for a read, six for a write, three for turnaround. An off-by-one in the counters therefore shows up as a short strobe or an early capture. The bench's memory model returns a marker word until the read access has lasted its full time, so an early capture returns wrong data. A monitor measures strobe widths and the gaps between reads and writes on every access.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int CLK_NS = 10,
  parameter int AW     = 17,
  parameter int DW     = 16,
  parameter int T_CYC  = 55,
  parameter int T_ACC  = 55,
  parameter int T_OED  = 25,
  parameter int T_WPW  = 40,
  parameter int T_DSU  = 25,
  parameter int T_LANE = 50,
  parameter int T_REL  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_bmask,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  function automatic int cyc(int ns);
    int c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LW     = DW / 2;
  localparam int N_RD   = mx(mx(cyc(T_CYC), cyc(T_ACC)), cyc(T_OED));
  localparam int N_WR   = mx(mx(cyc(T_CYC), cyc(T_WPW)), mx(cyc(T_DSU), cyc(T_LANE)));
  localparam int N_TURN = cyc(T_REL);
  localparam int CW     = $clog2(mx(mx(N_RD, N_WR), N_TURN) + 1);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_RD, S_WR} state_t;
  state_t state, state_n;

  logic [CW-1:0] cnt;
  logic          op_wr, have_last, last_wr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    mask_q;
  logic [1:0]    mask_nx;
  logic          accept, acc_nx;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mask_nx   = accept ? req_bmask : mask_q;
  assign acc_nx    = (state_n == S_RD) || (state_n == S_WR);

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE: if (req_valid)
                state_n = (have_last && last_wr != req_write) ? S_TURN
                        : (req_write ? S_WR : S_RD);
      S_TURN: if (cnt == '0) state_n = op_wr ? S_WR : S_RD;
      default: if (cnt == '0) state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      op_wr     <= 1'b0;
      have_last <= 1'b0;
      last_wr   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state <= state_n;
      if (state_n != state)
        cnt <= (state_n == S_TURN) ? CW'(N_TURN - 1)
             : (state_n == S_RD)   ? CW'(N_RD - 1)
             :                       CW'(N_WR - 1);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      if (accept) begin
        op_wr   <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_bmask;
      end
      if (acc_nx && state_n != state) begin
        have_last <= 1'b1;
        last_wr   <= (state_n == S_WR);
      end
      mem_ce_n  <= !acc_nx;
      mem_we_n  <= !(state_n == S_WR);
      mem_oe_n  <= !(state_n == S_RD);
      mem_ub_n  <= !(acc_nx && mask_nx[1]);
      mem_lb_n  <= !(acc_nx && mask_nx[0]);
      mem_dq_oe <= (state_n == S_WR);
      if (state == S_RD && cnt == '0) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem_dq_i & {{LW{mask_q[1]}}, {LW{mask_q[0]}}};
      end else begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

module sram_ctrl_chk #(
  parameter int N_WR = 6
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic ub_n,
  input logic lb_n,
  input logic dq_oe
);
  logic [15:0] we_lo;
  always_ff @(posedge clk) begin
    if (!rst_n) we_lo <= '0;
    else if (!we_n) we_lo <= we_lo + 1'b1;
    else we_lo <= '0;
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && oe_n && ub_n && lb_n && !dq_oe)); // R1
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && !$past(we_n)) |-> (we_lo >= 16'(N_WR))); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && !we_n && oe_n)); // R7
  AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready); // R10
endmodule

bind sram_ctrl sram_ctrl_chk #(.N_WR(N_WR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
  .ub_n(mem_ub_n), .lb_n(mem_lb_n), .dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  localparam int TCLK   = 10;
  localparam int EXP_RD = (55 + TCLK - 1) / TCLK;
  localparam int EXP_WR = (55 + TCLK - 1) / TCLK;
  localparam int EXP_TN = (25 + TCLK - 1) / TCLK;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  sram_ctrl #(.CLK_NS(TCLK)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Memory model: 256 words, data valid only after the full access time
  logic [15:0] mem [0:255];
  int rd_age = 0;
  wire rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
  wire wr_act = !mem_ce_n && !mem_we_n;
  wire [7:0] widx = mem_addr[7:0];
  assign mem_dq_i = (rd_act && rd_age >= EXP_RD - 1)
                  ? {mem_ub_n ? 8'hFF : mem[widx][15:8], mem_lb_n ? 8'hFF : mem[widx][7:0]}
                  : 16'hDEAD;
  always @(posedge clk) rd_age <= rd_act ? rd_age + 1 : 0;

  // Monitor, sampled on the falling edge
  int gap = 0, we_len = 0, rd_len = 0;
  bit have_prev = 0, prev_wr = 0, was_act = 0, was_wr = 0, was_rd = 0;
  logic [16:0] a0; logic [15:0] d0;
  always @(negedge clk) if (rst_n) begin
    chk(!mem_dq_oe || (wr_act && mem_oe_n), "R7 drive only in write", mem_dq_oe, 0);
    chk(!(!mem_we_n && !mem_oe_n), "R8 no WE/OE overlap", {mem_we_n, mem_oe_n}, 2'b11);
    if (rd_act || wr_act) begin
      if (!was_act) begin
        if (have_prev && prev_wr != wr_act)
          chk(gap >= EXP_TN, "R9 turnaround gap", gap, EXP_TN);
        a0 = mem_addr; d0 = mem_dq_o;
      end
      if (wr_act) begin
        chk(mem_addr == a0 && mem_dq_o == d0 && mem_oe_n, "R2 stable write", {mem_addr, 15'd0}, {a0, 15'd0});
        mem[widx][7:0]  <= mem_lb_n ? mem[widx][7:0]  : mem_dq_o[7:0];
        mem[widx][15:8] <= mem_ub_n ? mem[widx][15:8] : mem_dq_o[15:8];
        we_len++;
      end else begin
        rd_len++;
      end
      gap = 0; have_prev = 1; prev_wr = wr_act;
    end else begin
      gap++;
    end
    if (was_wr && !wr_act) begin
      chk(we_len == EXP_WR && mem_ce_n && mem_we_n, "R2 write width", we_len, EXP_WR);
      we_len = 0;
    end
    if (was_rd && !rd_act) begin
      chk(rd_len == EXP_RD, "R4 read width", rd_len, EXP_RD);
      rd_len = 0;
    end
    was_act = rd_act || wr_act; was_wr = wr_act; was_rd = rd_act;
  end

  task automatic issue(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_write = w; req_addr = a; req_wdata = d; req_bmask = m; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 busy after accept", req_ready, 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    issue(1, a, d, m);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] m, input logic [15:0] exp, input string tag);
    int n = 0;
    issue(0, a, 16'h0, m);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && req_ready,
        "R1 standby after read", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1f);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
        "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'h3e);
    chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_word;
    do_write(17'h00005, 16'h1234, 2'b11);
    do_read(17'h00005, 2'b11, 16'h1234, "R2 R4 word readback");
    do_write(17'h1FF06, 16'hBEEF, 2'b11);
    do_write(17'h00009, 16'hC0DE, 2'b11);
    do_read(17'h1FF06, 2'b11, 16'hBEEF, "R4 high address readback");
    do_read(17'h00009, 2'b11, 16'hC0DE, "R4 back-to-back read");
  endtask

  task automatic t_lanes;
    do_write(17'h00007, 16'hAAAA, 2'b11);
    do_write(17'h00007, 16'h5501, 2'b01);
    do_read(17'h00007, 2'b11, 16'hAA01, "R3 lower lane write");
    do_write(17'h00007, 16'h77FF, 2'b10);
    do_read(17'h00007, 2'b11, 16'h7701, "R3 upper lane write");
  endtask

  task automatic t_read_lanes;
    do_read(17'h00007, 2'b01, 16'h0001, "R5 lower lane read");
    do_read(17'h00007, 2'b10, 16'h7700, "R5 upper lane read");
  endtask

  task automatic t_none;
    do_write(17'h00007, 16'hFFFF, 2'b00);
    do_read(17'h00007, 2'b11, 16'h7701, "R6 empty mask write");
    do_read(17'h00007, 2'b00, 16'h0000, "R6 empty mask read");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_word();
    t_lanes();
    t_read_lanes();
    t_none();
    repeat (5) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired actual=busy expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule